// File: doc/BRIEF.md
# CAN Bit-Level Front End

This block is the thin layer between the CAN transceiver pins and the protocol engine. On the receive side it brings the asynchronous receive pin into the clock domain and decides one bit value per bit time. It keeps a short window of samples, one per time-quantum strobe. When the external bit-timing unit marks the sample point, it produces either that one sample or a majority vote over the last three samples. The decided bit is registered and comes with a single-cycle valid pulse. On the transmit side it registers the engine's transmit bit onto the transmit pin.

A self-test loop-back mode disconnects both pins. The transmit pin is held recessive, and the engine's own transmit bit is fed straight into the sampler. While the engine signals the acknowledge slot, the looped receive input is forced dominant, so the node acknowledges its own frame. The engine itself is not altered by loop-back, so it still reports both sending and receiving the looped frame.

The loop-back and sampling-mode settings live in a small mode register. That register only accepts writes while the freeze flag is high.

Top module: `can_bit_frontend`

## Requirements
- R1: After reset, both mode bits read 0 (single sampling, loop-back off), `tx_pin` is 1 and `rx_valid` is 0.
- R2: With triple sampling off, `rx_bit` equals the receive input sampled on the clock edge where `tq_strobe` and `sp_strobe` are both high. The receive pin passes through a two-flop synchroniser, so a pin value must be stable for two clocks before that edge.
- R3: With triple sampling on, `rx_bit` is the majority of three samples. These are the samples taken on the last two `tq_strobe` edges before the sample point plus the sample on the sample-point edge.
- R4: `rx_valid` is high for exactly the one cycle after each sample-point edge, and `rx_bit` holds its value until the next sample point.
- R5: With loop-back on, `rx_pin` has no effect, and the sampler sees `eng_tx_bit` directly with no synchroniser delay.
- R6: With loop-back on, `tx_pin` is 1. With loop-back off, `tx_pin` equals `eng_tx_bit` delayed by one clock.
- R7: With loop-back on and `ack_slot` high, the sampler sees dominant 0 whatever `eng_tx_bit` is. With loop-back off, `ack_slot` has no effect.
- R8: A write with `cfg_we` high loads the mode bits only if `freeze` is high in the same cycle. Bit 0 of `cfg_wdata` is loop-back and bit 1 is triple sampling. Writes with `freeze` low are ignored. The current bits are visible on `mode_loop` and `mode_triple`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pin | input | 1 | Asynchronous receive pin from the transceiver |
| tx_pin | output | 1 | Registered transmit pin to the transceiver |
| eng_tx_bit | input | 1 | Transmit bit from the protocol engine |
| tq_strobe | input | 1 | One-cycle pulse per time quantum, takes a sample |
| sp_strobe | input | 1 | Marks the `tq_strobe` that is the sample point |
| ack_slot | input | 1 | High while the engine is in the acknowledge slot |
| freeze | input | 1 | Freeze-mode flag, gates configuration writes |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 2 | Bit 0 loop-back, bit 1 triple sampling |
| mode_loop | output | 1 | Current loop-back setting |
| mode_triple | output | 1 | Current triple-sampling setting |
| rx_bit | output | 1 | Decided bit at the last sample point |
| rx_valid | output | 1 | One-cycle pulse with a new `rx_bit` |

## Verification
The bench sweeps all eight three-sample patterns in every combination of sampling mode and loop-back. In loop-back it drives the pin opposite to the engine bit, so a design that still listened to the pin, or that voted over the wrong window, decides the wrong bit. Patterns where the majority differs from the last sample show up a design that ignores the triple setting. The acknowledge slot is exercised with loop-back on and off, to catch a design that forces dominant outside loop-back or forgets to force it inside. Configuration writes with freeze low catch a register that accepts writes at any time.

// File: rtl/can_fe_pkg.sv
package can_fe_pkg;
  localparam int CFG_W      = 2;
  localparam int LOOP_BIT   = 0;
  localparam int TRIPLE_BIT = 1;

  typedef struct packed {
    logic triple;
    logic loop;
  } fe_mode_t;
endpackage

// File: rtl/can_fe_cfg.sv
module can_fe_cfg
  import can_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output fe_mode_t         mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0;
    end else if (we && freeze) begin
      mode.loop   <= wdata[LOOP_BIT];
      mode.triple <= wdata[TRIPLE_BIT];
    end
  end

  // R8
  cfg_frozen_only_chk: assert property (@(posedge clk) disable iff (rst)
    !freeze |=> $stable(mode));
endmodule

// File: rtl/can_fe_sync.sv
module can_fe_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/can_fe_sampler.sv
module can_fe_sampler #(
  parameter int NSAMP = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic tq,
  input  logic sp,
  input  logic triple,
  output logic bit_q,
  output logic valid_q
);
  localparam int WIN_W = NSAMP - 1;
  localparam int CNT_W = $clog2(NSAMP + 1);
  localparam int HALF  = NSAMP / 2;

  logic [WIN_W-1:0] win;
  logic [CNT_W-1:0] votes;
  logic             maj;

  always_ff @(posedge clk) begin
    if (rst)     win <= '1;
    else if (tq) win <= {win[WIN_W-2:0], din};
  end

  always_comb begin
    votes = CNT_W'(din);
    for (int i = 0; i < WIN_W; i++) votes = votes + CNT_W'(win[i]);
    maj = (votes > CNT_W'(HALF));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q   <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      valid_q <= tq && sp;
      if (tq && sp) bit_q <= triple ? maj : din;
    end
  end

  // R4
  valid_after_sp_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> $past(tq && sp));
  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(tq && sp) |=> $stable(bit_q));
  // R2
  single_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (tq && sp && !triple) |=> (bit_q == $past(din)));
endmodule

// File: rtl/can_bit_frontend.sv
module can_bit_frontend
  import can_fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NSAMP       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_pin,
  output logic             tx_pin,
  input  logic             eng_tx_bit,
  input  logic             tq_strobe,
  input  logic             sp_strobe,
  input  logic             ack_slot,
  input  logic             freeze,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             mode_loop,
  output logic             mode_triple,
  output logic             rx_bit,
  output logic             rx_valid
);
  fe_mode_t mode;
  logic     rx_sync;
  logic     loop_src;
  logic     samp_in;

  can_fe_cfg u_cfg (
    .clk(clk), .rst(rst), .freeze(freeze),
    .we(cfg_we), .wdata(cfg_wdata), .mode(mode)
  );

  can_fe_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(rx_pin), .q(rx_sync)
  );

  assign loop_src = ack_slot ? 1'b0 : eng_tx_bit;
  assign samp_in  = mode.loop ? loop_src : rx_sync;

  can_fe_sampler #(.NSAMP(NSAMP)) u_samp (
    .clk(clk), .rst(rst), .din(samp_in), .tq(tq_strobe), .sp(sp_strobe),
    .triple(mode.triple), .bit_q(rx_bit), .valid_q(rx_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_pin <= 1'b1;
    else     tx_pin <= mode.loop ? 1'b1 : eng_tx_bit;
  end

  assign mode_loop   = mode.loop;
  assign mode_triple = mode.triple;

  // R6
  tx_recessive_chk: assert property (@(posedge clk) disable iff (rst)
    mode.loop |=> tx_pin);
  // R6
  tx_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !mode.loop |=> (tx_pin == $past(eng_tx_bit)));
  // R7
  self_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (mode.loop && ack_slot && tq_strobe && sp_strobe && !mode.triple) |=> !rx_bit);
endmodule

// File: tb/sim_can_bit_frontend.sv
module sim_can_bit_frontend;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_pin = 1'b1, eng_tx_bit = 1'b1, tq_strobe = 1'b0, sp_strobe = 1'b0;
  logic ack_slot = 1'b0, freeze = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_wdata = 2'b00;
  logic tx_pin, mode_loop, mode_triple, rx_bit, rx_valid;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_bit_frontend u0 (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .tx_pin(tx_pin),
    .eng_tx_bit(eng_tx_bit), .tq_strobe(tq_strobe), .sp_strobe(sp_strobe),
    .ack_slot(ack_slot), .freeze(freeze), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mode_loop(mode_loop), .mode_triple(mode_triple),
    .rx_bit(rx_bit), .rx_valid(rx_valid)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic frz, input logic [1:0] d);
    @(negedge clk);
    freeze = frz; cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; freeze = 1'b0;
  endtask

  // One time quantum: present b on the active source, let it settle, strobe.
  task automatic step(input logic b, input logic sp, input logic loop, input logic ack);
    if (loop) begin eng_tx_bit = b; rx_pin = ~b; end
    else      begin rx_pin = b; eng_tx_bit = ~b; end
    ack_slot = ack;
    repeat (3) @(negedge clk);
    tq_strobe = 1'b1; sp_strobe = sp;
    @(negedge clk);
    tq_strobe = 1'b0; sp_strobe = 1'b0; ack_slot = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 mode_loop", mode_loop, 1'b0);
    chk("R1 mode_triple", mode_triple, 1'b0);
    chk("R1 tx_pin", tx_pin, 1'b1);
    chk("R1 rx_valid", rx_valid, 1'b0);

    // R8 write ignored outside freeze
    write_cfg(1'b0, 2'b11);
    chk("R8 loop ignored", mode_loop, 1'b0);
    chk("R8 triple ignored", mode_triple, 1'b0);

    // R6 transmit follows engine with loop-back off
    @(negedge clk); eng_tx_bit = 1'b0;
    @(negedge clk); chk("R6 tx follows 0", tx_pin, 1'b0);
    eng_tx_bit = 1'b1;
    @(negedge clk); chk("R6 tx follows 1", tx_pin, 1'b1);

    for (int m = 0; m < 4; m++) begin
      logic lp, tr;
      lp = m[0]; tr = m[1];
      write_cfg(1'b1, {tr, lp});
      chk("R8 loop written", mode_loop, lp);
      chk("R8 triple written", mode_triple, tr);
      for (int p = 0; p < 8; p++) begin
        logic [2:0] pat;
        logic exp;
        pat = 3'(p);
        exp = tr ? ((32'(pat[0]) + 32'(pat[1]) + 32'(pat[2])) >= 2) : pat[0];
        step(pat[2], 1'b0, lp, 1'b0);
        step(pat[1], 1'b0, lp, 1'b0);
        step(pat[0], 1'b1, lp, 1'b0);
        if (!tr && !lp) chk("R2 single sample", rx_bit, exp);
        else if (tr)    chk("R3 majority", rx_bit, exp);
        else            chk("R5 loop source", rx_bit, exp);
        chk("R4 valid pulse", rx_valid, 1'b1);
        if (lp) chk("R6 tx recessive", tx_pin, 1'b1);
        @(negedge clk);
        chk("R4 valid drops", rx_valid, 1'b0);
        chk("R4 bit held", rx_bit, exp);
      end
    end

    // R7 self-acknowledge in loop-back, single sampling
    write_cfg(1'b1, 2'b01);
    step(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R7 forced dominant", rx_bit, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R7 no ack recessive", rx_bit, 1'b1);
    // R7 ack slot has no effect with loop-back off
    write_cfg(1'b1, 2'b00);
    step(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R7 ack ignored normal", rx_bit, 1'b1);

    // R2 synchroniser: pin change one clock before strobe not yet seen
    rx_pin = 1'b1;
    repeat (3) @(negedge clk);
    rx_pin = 1'b0;
    tq_strobe = 1'b1; sp_strobe = 1'b1;
    @(negedge clk);
    tq_strobe = 1'b0; sp_strobe = 1'b0;
    chk("R2 synchroniser delay", rx_bit, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule